// File: doc/BRIEF.md
# Four-Stage Audio Timer Channel

This block is one timer channel of an audio sound processor. The wait-state logic sends it a clock-advance amount with a valid strobe. A prescale accumulator collects these amounts. Each time the accumulator crosses a fixed threshold, the threshold is taken off and a phase bit toggles. Two global control bits gate the phase bit into a line: one must be set to run, and the other, when set, halts. Every 1-to-0 transition of that line steps an 8-bit divider, but only while the channel's own enable bit is high. When the divider reaches a software-programmed period, it restarts and a 4-bit tick counter advances. Software reads the tick counter.

The threshold is a parameter, so the same design serves both the fast and the slow channel variants. When the threshold is a power of two, a generate branch picks a carry-based wrap in place of a compare-and-subtract. A read strobe clears the tick counter on the clock where it is taken. A 0-to-1 edge of the channel enable restarts both the divider and the tick counter.

Top module: `audio_tick_timer`

## Requirements
- R1: On a clock with `adv_valid` high, the accumulator adds `adv_amount`. If the sum is at least PRESCALE, PRESCALE is subtracted and the phase bit toggles. Otherwise the sum is kept and the phase holds. With `adv_valid` low, neither changes.
- R2: The gated line equals the phase bit while `glb_run` is 1 and `glb_halt` is 0. Otherwise it is 0, and no phase activity reaches the divider.
- R3: Only a 1-to-0 transition of the gated line steps the divider. A 0-to-1 transition never does.
- R4: While `ch_enable` is 0, line falls leave the divider and `tick_count` unchanged.
- R5: When a step brings the divider equal to `period`, the divider returns to 0 and `tick_count` increases by 1. The falling edge is seen on the clock after the phase toggles.
- R6: A `period` of 0 gives a divide ratio of 256 line falls per tick.
- R7: `tick_count` is 4 bits wide and wraps from 15 to 0.
- R8: `tick_count` shows the stored count. A clock with `rd_strobe` high clears it. If a tick arrives on that same clock, the result is 1.
- R9: A clock on which `ch_enable` is 1 after being 0 clears the divider and `tick_count`, and counts no line fall.
- R10: A fall of the gated line caused by `glb_run` clearing or `glb_halt` setting while the phase is 1 counts like any other fall.
- R11: While `rst_n` is low, the accumulator, phase, line, divider and `tick_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | Advance amount is valid this clock |
| adv_amount | input | ADV_W | Clock-advance amount |
| glb_run | input | 1 | Global timer run bit |
| glb_halt | input | 1 | Global timer halt bit |
| ch_enable | input | 1 | Channel enable |
| period | input | DIV_W | Divider period, 0 means 256 |
| rd_strobe | input | 1 | Read of the tick counter, clears it |
| tick_count | output | OUT_W | Tick counter value |

## Verification
The bench builds the block with PRESCALE = 10 and ADV_W = 3. These values select the compare-and-subtract branch of the prescaler. A small threshold also makes the phase toggle every one or two advances. That brings the 4-bit tick wrap and the 256-fall divide of a zero period within reach in about a thousand cycles. A threshold of 10 is not a power of two, so the sums land off the threshold and carry a remainder over. This exercises holding the remainder without a toggle, as well as the single-cycle falls caused by the global run and halt bits.

// File: rtl/atimer_pkg.sv
package atimer_pkg;

   // Events produced by the line gate and consumed by the divider
   typedef struct packed {
      logic fall;     // gated line went 1 -> 0 this cycle
      logic en_rise;  // channel enable went 0 -> 1 this cycle
      logic ch_on;    // channel enable level
   } atimer_evt_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/atimer_prescale.sv
module atimer_prescale #(
   parameter int PRESCALE = 128,
   parameter int ADV_W    = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         adv_valid,
   input  logic [ADV_W-1:0]             adv_amount,
   output logic [$clog2(PRESCALE)-1:0]  acc_o,
   output logic                         phase_o
);
   localparam int  ACC_W = $clog2(PRESCALE);
   localparam int  SUM_W = ACC_W + 1;
   localparam bit  POW2  = atimer_pkg::is_pow2(PRESCALE);

   logic [ACC_W-1:0] acc_q;
   logic             phase_q;
   logic [SUM_W-1:0] sum;
   logic [ACC_W-1:0] acc_n;
   logic             over;

   assign sum = {1'b0, acc_q} + SUM_W'(adv_amount);

   generate
      if (POW2) begin : g_carry
         // threshold is 2**ACC_W: the carry bit is the crossing
         assign over  = sum[ACC_W];
         assign acc_n = sum[ACC_W-1:0];
      end else begin : g_compare
         logic [SUM_W-1:0] diff;
         assign over  = (sum >= SUM_W'(PRESCALE));
         assign diff  = sum - SUM_W'(PRESCALE);
         assign acc_n = over ? diff[ACC_W-1:0] : sum[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         phase_q <= 1'b0;
      end else if (adv_valid) begin
         acc_q <= acc_n;
         if (over) phase_q <= ~phase_q;
      end
   end

   assign acc_o   = acc_q;
   assign phase_o = phase_q;
endmodule

// File: rtl/atimer_gate.sv
module atimer_gate (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     phase,
   input  logic                     glb_run,
   input  logic                     glb_halt,
   input  logic                     ch_enable,
   output logic                     line_now_o,
   output logic                     line_q_o,
   output logic                     en_q_o,
   output atimer_pkg::atimer_evt_t  evt_o
);
   logic line_now;
   logic line_q;
   logic en_q;

   // evaluated every cycle so a global-bit change can create a fall
   assign line_now = phase & glb_run & ~glb_halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         line_q <= line_now;
         en_q   <= ch_enable;
      end
   end

   assign evt_o.fall    = line_q & ~line_now;
   assign evt_o.en_rise = ch_enable & ~en_q;
   assign evt_o.ch_on   = ch_enable;

   assign line_now_o = line_now;
   assign line_q_o   = line_q;
   assign en_q_o     = en_q;
endmodule

// File: rtl/atimer_divider.sv
module atimer_divider #(
   parameter int DIV_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  atimer_pkg::atimer_evt_t  evt,
   input  logic [DIV_W-1:0]         period,
   output logic [DIV_W-1:0]         cnt_o,
   output logic                     hit_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] nxt;
   logic             step;

   assign nxt   = cnt_q + 1'b1;  // natural wrap: period 0 means 2**DIV_W
   assign step  = evt.fall & evt.ch_on & ~evt.en_rise;
   assign hit_o = step & (nxt == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (evt.en_rise) cnt_q <= '0;
      else if (hit_o)       cnt_q <= '0;
      else if (step)        cnt_q <= nxt;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/atimer_outcnt.sv
module atimer_outcnt #(
   parameter int OUT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             clr,
   input  logic             rd,
   output logic [OUT_W-1:0] cnt_o
);
   logic [OUT_W-1:0] cnt_q;
   logic [OUT_W-1:0] base;
   logic [OUT_W-1:0] nxt;

   assign base = rd ? '0 : cnt_q;
   assign nxt  = base + {{(OUT_W-1){1'b0}}, hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= nxt;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/audio_tick_timer.sv
module audio_tick_timer #(
   parameter int PRESCALE = 128,
   parameter int ADV_W    = 5,
   parameter int DIV_W    = 8,
   parameter int OUT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_valid,
   input  logic [ADV_W-1:0] adv_amount,
   input  logic             glb_run,
   input  logic             glb_halt,
   input  logic             ch_enable,
   input  logic [DIV_W-1:0] period,
   input  logic             rd_strobe,
   output logic [OUT_W-1:0] tick_count
);
   localparam int ACC_W = $clog2(PRESCALE);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("PRESCALE must be at least 2");
      end
      if ((2 ** ADV_W) - 1 > PRESCALE) begin : g_bad_adv
         $error("largest advance must not exceed PRESCALE");
      end
      if (DIV_W < 1 || OUT_W < 1) begin : g_bad_width
         $error("counter widths must be positive");
      end
   endgenerate

   logic [ACC_W-1:0]        acc;
   logic                    phase;
   logic                    line_now;
   logic                    line_q;
   logic                    en_q;
   atimer_pkg::atimer_evt_t evt;
   logic [DIV_W-1:0]        div_cnt;
   logic                    hit;

   atimer_prescale #(.PRESCALE(PRESCALE), .ADV_W(ADV_W)) u_prescale (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_valid  (adv_valid),
      .adv_amount (adv_amount),
      .acc_o      (acc),
      .phase_o    (phase)
   );

   atimer_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .glb_run    (glb_run),
      .glb_halt   (glb_halt),
      .ch_enable  (ch_enable),
      .line_now_o (line_now),
      .line_q_o   (line_q),
      .en_q_o     (en_q),
      .evt_o      (evt)
   );

   atimer_divider #(.DIV_W(DIV_W)) u_divider (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .period (period),
      .cnt_o  (div_cnt),
      .hit_o  (hit)
   );

   atimer_outcnt #(.OUT_W(OUT_W)) u_outcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .clr   (evt.en_rise),
      .rd    (rd_strobe),
      .cnt_o (tick_count)
   );
endmodule

// File: rtl/atimer_checker.sv
module atimer_checker #(
   parameter int PRESCALE = 128,
   parameter int ADV_W    = 5,
   parameter int DIV_W    = 8,
   parameter int OUT_W    = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         adv_valid,
   input logic [ADV_W-1:0]             adv_amount,
   input logic                         glb_run,
   input logic                         glb_halt,
   input logic                         ch_enable,
   input logic [DIV_W-1:0]             period,
   input logic                         rd_strobe,
   input logic [OUT_W-1:0]             tick_count,
   input logic [$clog2(PRESCALE)-1:0]  acc,
   input logic                         phase,
   input logic                         line_now,
   input logic                         line_q,
   input logic                         en_q,
   input logic [DIV_W-1:0]             div_cnt
);
   p_acc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(acc) < PRESCALE);

   p_cross_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_valid && (int'(acc) + int'(adv_amount) >= PRESCALE)) |=> (phase != $past(phase)));

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_valid |=> ($stable(acc) && $stable(phase)));

   p_line_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_run || glb_halt) |=> !line_q);

   p_fall_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(line_q && !line_now) && !(ch_enable && !en_q)) |=> $stable(div_cnt));

   p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_enable && !rd_strobe) |=> ($stable(div_cnt) && $stable(tick_count)));

   p_period_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q && !line_now && ch_enable && en_q && !rd_strobe &&
       (DIV_W'(div_cnt + 1'b1) == period))
      |=> (div_cnt == '0 && tick_count == OUT_W'($past(tick_count) + 1'b1)));

   p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> (tick_count <= OUT_W'(1)));

   p_enable_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_enable && !en_q) |=> (div_cnt == '0 && tick_count == '0));
endmodule

bind audio_tick_timer atimer_checker #(
   .PRESCALE(PRESCALE), .ADV_W(ADV_W), .DIV_W(DIV_W), .OUT_W(OUT_W)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .adv_valid  (adv_valid),
   .adv_amount (adv_amount),
   .glb_run    (glb_run),
   .glb_halt   (glb_halt),
   .ch_enable  (ch_enable),
   .period     (period),
   .rd_strobe  (rd_strobe),
   .tick_count (tick_count),
   .acc        (acc),
   .phase      (phase),
   .line_now   (line_now),
   .line_q     (line_q),
   .en_q       (en_q),
   .div_cnt    (div_cnt)
);

// File: tb/audio_tick_timer_bench.sv
`timescale 1ns/1ps
module audio_tick_timer_bench;
   localparam int PRESCALE = 10;
   localparam int ADV_W    = 3;
   localparam int DIV_W    = 8;
   localparam int OUT_W    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             adv_valid = 1'b0;
   logic [ADV_W-1:0] adv_amount = '0;
   logic             glb_run = 1'b0;
   logic             glb_halt = 1'b0;
   logic             ch_enable = 1'b0;
   logic [DIV_W-1:0] period = 8'd1;
   logic             rd_strobe = 1'b0;
   logic [OUT_W-1:0] tick_count;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string cur_req = "R11";

   always #5 clk = ~clk;

   audio_tick_timer #(.PRESCALE(PRESCALE), .ADV_W(ADV_W), .DIV_W(DIV_W), .OUT_W(OUT_W))
      u_audio_tick_timer (
         .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_amount(adv_amount),
         .glb_run(glb_run), .glb_halt(glb_halt), .ch_enable(ch_enable),
         .period(period), .rd_strobe(rd_strobe), .tick_count(tick_count));

   // behavioural reference
   int m_acc, m_sum, m_div, m_tick;
   bit m_phase, m_line, m_en, m_now, m_fall;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = 0; m_phase = 0; m_line = 0; m_en = 0; m_div = 0; m_tick = 0;
      end else begin
         m_now  = m_phase && glb_run && !glb_halt;
         m_fall = m_line && !m_now;
         m_line = m_now;
         if (adv_valid) begin
            m_sum = m_acc + int'(adv_amount);
            if (m_sum >= PRESCALE) begin
               m_acc = m_sum - PRESCALE;
               m_phase = !m_phase;
            end else begin
               m_acc = m_sum;
            end
         end
         if (rd_strobe) m_tick = 0;
         if (ch_enable && !m_en) begin
            m_div = 0; m_tick = 0;
         end else if (m_fall && ch_enable) begin
            m_div = (m_div + 1) % 256;
            if (m_div == int'(period)) begin
               m_div = 0;
               m_tick = (m_tick + 1) % 16;
            end
         end
         m_en = ch_enable;
      end
   end

   // continuous comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (int'(tick_count) !== m_tick) begin
            failures++;
            $display("FAIL %s model compare: tick_count=%0d expected=%0d", cur_req, tick_count, m_tick);
         end
      end
   end

   task automatic cyc(input bit v, input int a, input bit r);
      @(negedge clk);
      adv_valid  = v;
      adv_amount = ADV_W'(a);
      rd_strobe  = r;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0);
   endtask

   // one phase toggle from acc 0: 7 then 3
   task automatic half();
      cyc(1, 7, 0);
      cyc(1, 3, 0);
   endtask

   task automatic fall_once();
      half();
      half();
   endtask

   task automatic ck(input string tag, input int exp);
      checks++;
      if (int'(tick_count) !== exp) begin
         failures++;
         $display("FAIL %s: tick_count=%0d expected=%0d", tag, tick_count, exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: tick_count=%0d expected=finish", tick_count);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      ck("R11 reset value", 0);
      rst_n = 1'b1;
      @(negedge clk);
      ck("R11 after reset", 0);

      cur_req = "R1";
      glb_run = 1'b1; ch_enable = 1'b1; period = 8'd1;
      idle(2);
      cyc(1, 4, 0); cyc(1, 4, 0);      // 8 < 10: no toggle
      idle(2);
      ck("R1 below threshold", 0);
      cyc(1, 2, 0);                    // 10: toggle to 1, acc 0
      cur_req = "R5";
      half();                          // toggle back: fall
      idle(2);
      ck("R5 period 1 tick", 1);

      cur_req = "R3";
      half();                          // rising only
      idle(2);
      ck("R3 rise ignored", 1);

      cur_req = "R8";
      cyc(0, 0, 1);
      cyc(0, 0, 0);
      ck("R8 read clears", 0);

      cur_req = "R10";
      glb_halt = 1'b1;                 // phase is 1: line falls
      idle(3);
      ck("R10 halt causes fall", 1);
      cur_req = "R2";
      half(); half();
      idle(2);
      ck("R2 halted line", 1);
      glb_halt = 1'b0;                 // line rises
      idle(2);
      ck("R3 release rise", 1);
      half();
      idle(2);
      ck("R5 after release", 2);

      cur_req = "R10";
      half();
      idle(2);
      glb_run = 1'b0;
      idle(2);
      ck("R10 run clear causes fall", 3);
      cur_req = "R2";
      half(); half();
      idle(2);
      glb_run = 1'b1;
      idle(2);
      half();
      idle(2);
      ck("R2 run gating", 4);

      cur_req = "R4";
      ch_enable = 1'b0;
      fall_once(); fall_once(); fall_once();
      idle(2);
      ck("R4 channel disabled", 4);

      cur_req = "R9";
      period = 8'd3;
      ch_enable = 1'b1;
      idle(2);
      ck("R9 enable rise clears", 0);
      fall_once(); fall_once();
      idle(2);
      ck("R9 divider at 2", 0);
      ch_enable = 1'b0; idle(1);
      ch_enable = 1'b1; idle(2);
      fall_once();
      idle(2);
      ck("R9 divider restarted", 0);
      cur_req = "R5";
      fall_once(); fall_once();
      idle(2);
      ck("R5 period 3 tick", 1);

      cur_req = "R8";
      fall_once(); fall_once(); fall_once();
      cyc(0, 0, 1);                    // tick and read on same clock
      cyc(0, 0, 0);
      ck("R8 read with tick", 1);

      cur_req = "R7";
      period = 8'd1;
      cyc(0, 0, 1);
      for (int i = 0; i < 16; i++) fall_once();
      idle(2);
      ck("R7 wrap to 0", 0);
      fall_once();
      idle(2);
      ck("R7 after wrap", 1);

      cur_req = "R6";
      period = 8'd0;
      cyc(0, 0, 1);
      for (int i = 0; i < 255; i++) fall_once();
      idle(2);
      ck("R6 255 falls", 0);
      fall_once();
      idle(2);
      ck("R6 256 falls", 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule